// File: doc/BRIEF.md
# Cross-Core Translation Prefetch Buffer

This block is a small, fully associative store that sits next to one core's data TLB and holds address translations pushed to it by other cores. When the local core misses in its TLB it presents the virtual page, context and page size to the lookup port. On a match the buffer returns the physical page and the identity of the core that pushed the entry in the same cycle, and the entry leaves the buffer at the next clock edge so that it can be refilled into the TLB. The reported identity lets the surrounding logic raise that core's confidence.

Remote cores write entries through the push port. Entries are kept in arrival order. A push into a full buffer displaces the oldest entry. Because a used entry always leaves the buffer, any displaced entry was never used, so every displacement produces a one-cycle bad-prefetch notice that names the core that pushed it. A push whose page and context already sit in the buffer is dropped. A lookup and a push may arrive in the same cycle: the lookup sees the contents from before the push, and the push sees the contents after the lookup has removed its entry.

Top module: `xcore_pfbuf`

## Requirements
- R1: After reset, and while reset is held, the buffer is empty: every lookup misses and `bad_valid` is low.
- R2: A lookup hits only when virtual page, context and page size all equal those of a stored entry. `lk_hit` rises in the same cycle, and `lk_ppn` and `lk_src` then give that entry's physical page and pushing core.
- R3: A lookup that hits removes the entry at the next clock edge, so a repeated lookup of the same key misses.
- R4: With `lk_valid` low, `lk_hit` stays low and no entry is removed.
- R5: The buffer holds up to DEPTH entries (16 by default), and all of them can be found by lookup.
- R6: A push into a full buffer, with no lookup hit in the same cycle, evicts the oldest entry. In the next cycle `bad_valid` is high and `bad_core` holds that entry's pushing core.
- R7: Age follows push order. Entries removed by hits drop out of that order, and an eviction takes the oldest entry that remains.
- R8: A push whose virtual page and context match a valid entry is ignored, and the stored physical page and pushing core stay as they were.
- R9: For a lookup and a push in the same cycle, the lookup does not see the pushed entry. The slot freed by a hit lets a push into a full buffer proceed without eviction. A push that matches only the entry being consumed is accepted.
- R10: `bad_valid` is high only in the cycle that follows an evicting push. It is a single-cycle pulse unless evicting pushes follow each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request after a local TLB miss |
| lk_vpn | input | VPN_W | Lookup virtual page |
| lk_ctx | input | CTX_W | Lookup context ID |
| lk_size | input | SZ_W | Lookup page size code |
| lk_hit | output | 1 | Lookup matched a stored entry (same cycle) |
| lk_ppn | output | PPN_W | Physical page of the matching entry |
| lk_src | output | CORE_W | Core that pushed the matching entry |
| push_valid | input | 1 | Remote core pushes a translation |
| push_vpn | input | VPN_W | Pushed virtual page |
| push_ctx | input | CTX_W | Pushed context ID |
| push_size | input | SZ_W | Pushed page size code |
| push_ppn | input | PPN_W | Pushed physical page |
| push_src | input | CORE_W | ID of the pushing core |
| bad_valid | output | 1 | Unused entry was evicted in the previous cycle |
| bad_core | output | CORE_W | Core the bad-prefetch notice is addressed to |

## Verification
The bench builds the buffer with DEPTH set to 4 and keeps every other width at its default. With only four slots, a few pushes fill the buffer, so eviction, age order after a removal from the middle, and the same-cycle lookup-plus-push cases at full occupancy all take only a handful of cycles. The bench walks a vector table through matching, consumption and duplicate dropping. Directed sequences then cover the full-buffer corners.

// File: rtl/pfbuf_pkg.sv
// Package: shared types for the cross-core prefetch buffer.
// Assumes nothing beyond being compiled before the modules that import it.
package pfbuf_pkg;

    // What the storage queue does with the push slot this cycle.
    typedef enum logic [1:0] {
        Q_HOLD   = 2'd0,   // no push is stored
        Q_APPEND = 2'd1,   // push is stored behind the youngest entry
        Q_EVICT  = 2'd2    // oldest entry drops out, push becomes youngest
    } q_action_e;

endpackage

// File: rtl/pfbuf_penc.sv
// Module: pfbuf_penc
// Turns a match vector into the index of its lowest set bit and an any flag.
// Assumes at most one bit is set in normal use. If more are set, the lowest wins.
module pfbuf_penc #(
    parameter int N     = 16,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top down so that the lowest set bit is written last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

    // Any match at all.
    assign any = |vec;

endmodule

// File: rtl/pfbuf_cam.sv
// Module: pfbuf_cam
// Compares every slot against the lookup key (page, context and size) and
// against the push key (page and context only, used to drop duplicates).
// Assumes the slot valid bits are already qualified by occupancy.
module pfbuf_cam #(
    parameter int DEPTH = 16,
    parameter int VPN_W = 20,
    parameter int CTX_W = 8,
    parameter int SZ_W  = 2
) (
    input  logic [DEPTH-1:0] slot_vld,
    input  logic [VPN_W-1:0] slot_vpn [DEPTH],
    input  logic [CTX_W-1:0] slot_ctx [DEPTH],
    input  logic [SZ_W-1:0]  slot_sz  [DEPTH],
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [CTX_W-1:0] lk_ctx,
    input  logic [SZ_W-1:0]  lk_size,
    input  logic [VPN_W-1:0] push_vpn,
    input  logic [CTX_W-1:0] push_ctx,
    output logic [DEPTH-1:0] lk_match,
    output logic [DEPTH-1:0] dup_match
);

    // One comparator pair per slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign lk_match[g]  = slot_vld[g]
                              && (slot_vpn[g] == lk_vpn)
                              && (slot_ctx[g] == lk_ctx)
                              && (slot_sz[g]  == lk_size);
        assign dup_match[g] = slot_vld[g]
                              && (slot_vpn[g] == push_vpn)
                              && (slot_ctx[g] == push_ctx);
    end

endmodule

// File: rtl/pfbuf_queue.sv
// Module: pfbuf_queue
// Age-ordered storage that collapses on removal. Slot 0 is the oldest entry
// and slots at or above the occupancy count are empty. A removal closes the
// gap by moving younger entries down. After that, the action appends the new
// entry or evicts slot 0 and writes the new entry into the top slot.
// Assumes rm_idx < occ when rm is set, and that Q_EVICT comes only when the
// buffer is full after the removal.
module pfbuf_queue
    import pfbuf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int VPN_W  = 20,
    parameter int CTX_W  = 8,
    parameter int SZ_W   = 2,
    parameter int PPN_W  = 20,
    parameter int CORE_W = 3,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int OCC_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rm,
    input  logic [IDX_W-1:0]  rm_idx,
    input  q_action_e         action,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [CTX_W-1:0]  wr_ctx,
    input  logic [SZ_W-1:0]   wr_sz,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [CORE_W-1:0] wr_src,
    output logic [DEPTH-1:0]  slot_vld,
    output logic [VPN_W-1:0]  slot_vpn [DEPTH],
    output logic [CTX_W-1:0]  slot_ctx [DEPTH],
    output logic [SZ_W-1:0]   slot_sz  [DEPTH],
    output logic [PPN_W-1:0]  slot_ppn [DEPTH],
    output logic [CORE_W-1:0] slot_src [DEPTH],
    output logic [OCC_W-1:0]  occ
);

    logic [VPN_W-1:0]  c_vpn [DEPTH];
    logic [CTX_W-1:0]  c_ctx [DEPTH];
    logic [SZ_W-1:0]   c_sz  [DEPTH];
    logic [PPN_W-1:0]  c_ppn [DEPTH];
    logic [CORE_W-1:0] c_src [DEPTH];
    logic [VPN_W-1:0]  n_vpn [DEPTH];
    logic [CTX_W-1:0]  n_ctx [DEPTH];
    logic [SZ_W-1:0]   n_sz  [DEPTH];
    logic [PPN_W-1:0]  n_ppn [DEPTH];
    logic [CORE_W-1:0] n_src [DEPTH];
    logic [OCC_W-1:0]  occ_c;
    logic [OCC_W-1:0]  occ_n;

    // Occupancy after the removal.
    assign occ_c = occ - OCC_W'(rm);

    // Close the gap left by a removed entry.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rm && (i >= int'(rm_idx)) && (i < DEPTH - 1)) begin
                c_vpn[i] = slot_vpn[i+1];
                c_ctx[i] = slot_ctx[i+1];
                c_sz[i]  = slot_sz[i+1];
                c_ppn[i] = slot_ppn[i+1];
                c_src[i] = slot_src[i+1];
            end else begin
                c_vpn[i] = slot_vpn[i];
                c_ctx[i] = slot_ctx[i];
                c_sz[i]  = slot_sz[i];
                c_ppn[i] = slot_ppn[i];
                c_src[i] = slot_src[i];
            end
        end
    end

    // Apply the push action on top of the collapsed contents.
    always_comb begin
        occ_n = occ_c;
        for (int i = 0; i < DEPTH; i++) begin
            n_vpn[i] = c_vpn[i];
            n_ctx[i] = c_ctx[i];
            n_sz[i]  = c_sz[i];
            n_ppn[i] = c_ppn[i];
            n_src[i] = c_src[i];
        end
        case (action)
            Q_APPEND: begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (OCC_W'(i) == occ_c) begin
                        n_vpn[i] = wr_vpn;
                        n_ctx[i] = wr_ctx;
                        n_sz[i]  = wr_sz;
                        n_ppn[i] = wr_ppn;
                        n_src[i] = wr_src;
                    end
                end
                occ_n = occ_c + OCC_W'(1);
            end
            Q_EVICT: begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    n_vpn[i] = c_vpn[i+1];
                    n_ctx[i] = c_ctx[i+1];
                    n_sz[i]  = c_sz[i+1];
                    n_ppn[i] = c_ppn[i+1];
                    n_src[i] = c_src[i+1];
                end
                n_vpn[DEPTH-1] = wr_vpn;
                n_ctx[DEPTH-1] = wr_ctx;
                n_sz[DEPTH-1]  = wr_sz;
                n_ppn[DEPTH-1] = wr_ppn;
                n_src[DEPTH-1] = wr_src;
            end
            default: ;
        endcase
    end

    // Occupancy register. Reset empties the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else        occ <= occ_n;
    end

    // Slot payload registers. Contents need no reset because occ gates them.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            slot_vpn[i] <= n_vpn[i];
            slot_ctx[i] <= n_ctx[i];
            slot_sz[i]  <= n_sz[i];
            slot_ppn[i] <= n_ppn[i];
            slot_src[i] <= n_src[i];
        end
    end

    // A slot is valid when it lies below the occupancy count.
    for (genvar g = 0; g < DEPTH; g++) begin : g_vld
        assign slot_vld[g] = (OCC_W'(g) < occ);
    end

endmodule

// File: rtl/xcore_pfbuf.sv
// Module: xcore_pfbuf
// Fully associative buffer for translations pushed by remote cores. A lookup
// hit is reported in the same cycle and the entry is consumed at the edge.
// Pushes are stored in age order. A push into a full buffer evicts the oldest
// entry and sends a registered bad-prefetch notice to the core that pushed it.
// Assumes the key set is kept unique by dropping pushes whose page and
// context match an entry that remains.
module xcore_pfbuf
    import pfbuf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int VPN_W  = 20,
    parameter int CTX_W  = 8,
    parameter int SZ_W   = 2,
    parameter int PPN_W  = 20,
    parameter int CORE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [CTX_W-1:0]  lk_ctx,
    input  logic [SZ_W-1:0]   lk_size,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [CORE_W-1:0] lk_src,
    input  logic              push_valid,
    input  logic [VPN_W-1:0]  push_vpn,
    input  logic [CTX_W-1:0]  push_ctx,
    input  logic [SZ_W-1:0]   push_size,
    input  logic [PPN_W-1:0]  push_ppn,
    input  logic [CORE_W-1:0] push_src,
    output logic              bad_valid,
    output logic [CORE_W-1:0] bad_core
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int OCC_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0]  slot_vld;
    logic [VPN_W-1:0]  slot_vpn [DEPTH];
    logic [CTX_W-1:0]  slot_ctx [DEPTH];
    logic [SZ_W-1:0]   slot_sz  [DEPTH];
    logic [PPN_W-1:0]  slot_ppn [DEPTH];
    logic [CORE_W-1:0] slot_src [DEPTH];
    logic [OCC_W-1:0]  occ;
    logic [DEPTH-1:0]  lk_match;
    logic [DEPTH-1:0]  dup_match;
    logic [DEPTH-1:0]  rm_mask;
    logic              lk_any;
    logic [IDX_W-1:0]  lk_idx;
    logic              dup;
    logic              accept;
    logic              evict;
    q_action_e         action;

    pfbuf_cam #(
        .DEPTH(DEPTH), .VPN_W(VPN_W), .CTX_W(CTX_W), .SZ_W(SZ_W)
    ) u_cam (
        .slot_vld (slot_vld),
        .slot_vpn (slot_vpn),
        .slot_ctx (slot_ctx),
        .slot_sz  (slot_sz),
        .lk_vpn   (lk_vpn),
        .lk_ctx   (lk_ctx),
        .lk_size  (lk_size),
        .push_vpn (push_vpn),
        .push_ctx (push_ctx),
        .lk_match (lk_match),
        .dup_match(dup_match)
    );

    pfbuf_penc #(.N(DEPTH), .IDX_W(IDX_W)) u_penc (
        .vec(lk_match),
        .any(lk_any),
        .idx(lk_idx)
    );

    // Lookup result comes straight from the storage in the same cycle.
    assign lk_hit = lk_valid && lk_any;
    assign lk_ppn = slot_ppn[lk_idx];
    assign lk_src = slot_src[lk_idx];

    // Ignore a duplicate only when the match survives this cycle's removal.
    assign rm_mask = lk_hit ? lk_match : '0;
    assign dup     = |(dup_match & ~rm_mask);
    assign accept  = push_valid && !dup;
    assign evict   = accept && !lk_hit && (occ == OCC_W'(DEPTH));

    // Choose the queue action for the push.
    always_comb begin
        if (evict)       action = Q_EVICT;
        else if (accept) action = Q_APPEND;
        else             action = Q_HOLD;
    end

    pfbuf_queue #(
        .DEPTH(DEPTH), .VPN_W(VPN_W), .CTX_W(CTX_W), .SZ_W(SZ_W),
        .PPN_W(PPN_W), .CORE_W(CORE_W), .IDX_W(IDX_W), .OCC_W(OCC_W)
    ) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .rm      (lk_hit),
        .rm_idx  (lk_idx),
        .action  (action),
        .wr_vpn  (push_vpn),
        .wr_ctx  (push_ctx),
        .wr_sz   (push_size),
        .wr_ppn  (push_ppn),
        .wr_src  (push_src),
        .slot_vld(slot_vld),
        .slot_vpn(slot_vpn),
        .slot_ctx(slot_ctx),
        .slot_sz (slot_sz),
        .slot_ppn(slot_ppn),
        .slot_src(slot_src),
        .occ     (occ)
    );

    // Register the bad-prefetch notice for the entry evicted this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_valid <= 1'b0;
            bad_core  <= '0;
        end else begin
            bad_valid <= evict;
            if (evict) bad_core <= slot_src[0];
        end
    end

endmodule

// File: rtl/pfbuf_checker.sv
// Module: pfbuf_checker
// Temporal checks on the prefetch buffer, bound to every xcore_pfbuf instance.
// Assumes the synchronous active-low reset of the checked block.
module pfbuf_checker #(
    parameter int DEPTH = 16,
    parameter int OCC_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             lk_hit,
    input logic             push_valid,
    input logic             bad_valid,
    input logic [OCC_W-1:0] occ
);

    a_r5_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(DEPTH));

    a_r4_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_hit);

    a_r1_empty_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> !lk_hit);

    a_r3_hit_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !push_valid) |=> (occ == $past(occ) - OCC_W'(1)));

    a_r6_bad_from_full: assert property (@(posedge clk) disable iff (!rst_n)
        bad_valid |-> ($past(push_valid) && !$past(lk_hit)
                       && ($past(occ) == OCC_W'(DEPTH))));

    a_r9_hit_no_evict: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |=> !bad_valid);

endmodule

bind xcore_pfbuf pfbuf_checker #(
    .DEPTH(DEPTH),
    .OCC_W(OCC_W)
) u_pfbuf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_hit    (lk_hit),
    .push_valid(push_valid),
    .bad_valid (bad_valid),
    .occ       (occ)
);

// File: tb/xcore_pfbuf_test.sv
module xcore_pfbuf_test;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_ctx = '0;
    logic [1:0]  lk_size = '0;
    logic        lk_hit;
    logic [19:0] lk_ppn;
    logic [2:0]  lk_src;
    logic        push_valid = 1'b0;
    logic [19:0] push_vpn = '0;
    logic [7:0]  push_ctx = '0;
    logic [1:0]  push_size = '0;
    logic [19:0] push_ppn = '0;
    logic [2:0]  push_src = '0;
    logic        bad_valid;
    logic [2:0]  bad_core;

    int total = 0;
    int bad = 0;

    // Values captured by the cycle task.
    logic        s_hit;
    logic [19:0] s_ppn;
    logic [2:0]  s_src;
    logic        s_bv;
    logic [2:0]  s_bc;

    always #2 clk = ~clk;

    xcore_pfbuf #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_ctx(lk_ctx), .lk_size(lk_size),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_src(lk_src),
        .push_valid(push_valid), .push_vpn(push_vpn), .push_ctx(push_ctx),
        .push_size(push_size), .push_ppn(push_ppn), .push_src(push_src),
        .bad_valid(bad_valid), .bad_core(bad_core)
    );

    typedef struct packed {
        logic        is_push;
        logic [19:0] vpn;
        logic [7:0]  ctx;
        logic [1:0]  sz;
        logic [19:0] ppn;
        logic [2:0]  src;
        logic        e_hit;
        logic [19:0] e_ppn;
        logic [2:0]  e_src;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 20'h10, 8'd1, 2'd0, 20'hA10, 3'd1, 1'b0, 20'h0,   3'd0}, // R5 store
        '{1'b1, 20'h11, 8'd1, 2'd1, 20'hA11, 3'd2, 1'b0, 20'h0,   3'd0}, // R5 store
        '{1'b0, 20'h10, 8'd2, 2'd0, 20'h0,   3'd0, 1'b0, 20'h0,   3'd0}, // R2 ctx differs
        '{1'b0, 20'h11, 8'd1, 2'd0, 20'h0,   3'd0, 1'b0, 20'h0,   3'd0}, // R2 size differs
        '{1'b0, 20'h12, 8'd1, 2'd0, 20'h0,   3'd0, 1'b0, 20'h0,   3'd0}, // R2 page differs
        '{1'b0, 20'h10, 8'd1, 2'd0, 20'h0,   3'd0, 1'b1, 20'hA10, 3'd1}, // R2 full match
        '{1'b0, 20'h10, 8'd1, 2'd0, 20'h0,   3'd0, 1'b0, 20'h0,   3'd0}, // R3 consumed
        '{1'b1, 20'h11, 8'd1, 2'd0, 20'hBBB, 3'd5, 1'b0, 20'h0,   3'd0}, // R8 duplicate
        '{1'b0, 20'h11, 8'd1, 2'd1, 20'h0,   3'd0, 1'b1, 20'hA11, 3'd2}, // R8 original kept
        '{1'b0, 20'h11, 8'd1, 2'd1, 20'h0,   3'd0, 1'b0, 20'h0,   3'd0}  // R3 consumed
    };

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock cycle of stimulus. Lookup outputs are taken before the edge,
    // and the bad-prefetch register just after it.
    task automatic cyc(input logic lv, input logic [19:0] lvpn, input logic [7:0] lctx,
                       input logic [1:0] lsz, input logic pv, input logic [19:0] pvpn,
                       input logic [7:0] pctx, input logic [1:0] psz,
                       input logic [19:0] pppn, input logic [2:0] psrc);
        @(negedge clk);
        lk_valid = lv; lk_vpn = lvpn; lk_ctx = lctx; lk_size = lsz;
        push_valid = pv; push_vpn = pvpn; push_ctx = pctx; push_size = psz;
        push_ppn = pppn; push_src = psrc;
        #1;
        s_hit = lk_hit; s_ppn = lk_ppn; s_src = lk_src;
        @(posedge clk);
        #1;
        s_bv = bad_valid; s_bc = bad_core;
        lk_valid = 1'b0; push_valid = 1'b0;
    endtask

    task automatic push(input logic [19:0] v, input logic [19:0] p, input logic [2:0] s);
        cyc(1'b0, '0, '0, '0, 1'b1, v, 8'd3, 2'd0, p, s);
    endtask

    task automatic look(input logic [19:0] v);
        cyc(1'b1, v, 8'd3, 2'd0, 1'b0, '0, '0, '0, '0, '0);
    endtask

    task automatic expect_hit(input string req, input logic eh,
                              input logic [19:0] ep, input logic [2:0] es);
        check(s_hit == eh, req, "hit", 32'(s_hit), 32'(eh));
        if (eh) begin
            check(s_ppn == ep, req, "ppn", 32'(s_ppn), 32'(ep));
            check(s_src == es, req, "src", 32'(s_src), 32'(es));
        end
    endtask

    task automatic expect_bad(input string req, input logic ev, input logic [2:0] ec);
        check(s_bv == ev, req, "bad_valid", 32'(s_bv), 32'(ev));
        if (ev) check(s_bc == ec, req, "bad_core", 32'(s_bc), 32'(ec));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        // R1 while reset is held: a push is not stored and no notice appears.
        cyc(1'b0, '0, '0, '0, 1'b1, 20'h55, 8'd3, 2'd0, 20'h1, 3'd1);
        check(bad_valid == 1'b0, "R1", "bad_valid in reset", 32'(bad_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        look(20'h55);
        expect_hit("R1", 1'b0, '0, '0);
        expect_bad("R1", 1'b0, '0);

        // Vector table for matching, consumption and duplicate dropping.
        for (int i = 0; i < NV; i++) begin
            if (TBL[i].is_push)
                cyc(1'b0, '0, '0, '0, 1'b1, TBL[i].vpn, TBL[i].ctx, TBL[i].sz,
                    TBL[i].ppn, TBL[i].src);
            else
                cyc(1'b1, TBL[i].vpn, TBL[i].ctx, TBL[i].sz, 1'b0, '0, '0, '0, '0, '0);
            expect_hit("R2", TBL[i].e_hit, TBL[i].e_ppn, TBL[i].e_src);
            expect_bad("R10", 1'b0, '0);
        end

        // R4: a lookup with lk_valid low neither hits nor removes.
        push(20'h40, 20'hC40, 3'd4);
        cyc(1'b0, 20'h40, 8'd3, 2'd0, 1'b0, '0, '0, '0, '0, '0);
        expect_hit("R4", 1'b0, '0, '0);
        look(20'h40);
        expect_hit("R4", 1'b1, 20'hC40, 3'd4);

        // R5, R6, R7: fill, consume from the middle, then evict twice.
        push(20'h20, 20'hD20, 3'd1);
        push(20'h21, 20'hD21, 3'd2);
        push(20'h22, 20'hD22, 3'd3);
        push(20'h23, 20'hD23, 3'd4);
        expect_bad("R5", 1'b0, '0);
        look(20'h21);
        expect_hit("R5", 1'b1, 20'hD21, 3'd2);
        push(20'h24, 20'hD24, 3'd5);
        expect_bad("R5", 1'b0, '0);
        push(20'h25, 20'hD25, 3'd6);
        expect_bad("R6", 1'b1, 3'd1);
        look(20'h77);
        expect_bad("R10", 1'b0, '0);
        push(20'h26, 20'hD26, 3'd7);
        expect_bad("R7", 1'b1, 3'd3);
        look(20'h20);
        expect_hit("R6", 1'b0, '0, '0);
        look(20'h22);
        expect_hit("R7", 1'b0, '0, '0);
        look(20'h23);
        expect_hit("R7", 1'b1, 20'hD23, 3'd4);
        look(20'h24);
        expect_hit("R5", 1'b1, 20'hD24, 3'd5);
        look(20'h25);
        expect_hit("R5", 1'b1, 20'hD25, 3'd6);
        look(20'h26);
        expect_hit("R5", 1'b1, 20'hD26, 3'd7);

        // R9: lookup and push of the same key in one cycle.
        cyc(1'b1, 20'h30, 8'd3, 2'd0, 1'b1, 20'h30, 8'd3, 2'd0, 20'hE30, 3'd1);
        expect_hit("R9", 1'b0, '0, '0);
        push(20'h31, 20'hE31, 3'd2);
        push(20'h32, 20'hE32, 3'd3);
        push(20'h33, 20'hE33, 3'd4);
        // Full: a hit frees a slot, so the push does not evict.
        cyc(1'b1, 20'h31, 8'd3, 2'd0, 1'b1, 20'h34, 8'd3, 2'd0, 20'hE34, 3'd6);
        expect_hit("R9", 1'b1, 20'hE31, 3'd2);
        expect_bad("R9", 1'b0, '0);
        // A push that matches only the entry being consumed is accepted.
        cyc(1'b1, 20'h32, 8'd3, 2'd0, 1'b1, 20'h32, 8'd3, 2'd0, 20'hF32, 3'd7);
        expect_hit("R9", 1'b1, 20'hE32, 3'd3);
        expect_bad("R9", 1'b0, '0);
        look(20'h32);
        expect_hit("R9", 1'b1, 20'hF32, 3'd7);
        look(20'h30);
        expect_hit("R9", 1'b1, 20'hE30, 3'd1);

        // R1: reset in mid-run empties the buffer.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        look(20'h33);
        expect_hit("R1", 1'b0, '0, '0);
        expect_bad("R1", 1'b0, '0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule